// File: doc/BRIEF.md
# Speculative Store Lineage Tracker

This block decides which entries of a shared store buffer a load on a given hardware context has to examine for aliasing, when several contexts run forked speculative paths at once. Each context owns a one-hot path tag and a search mask. The mask is the OR of its own tag with the tags of every unresolved branch that led to its path. Every store is stamped with the tag of the context that issued it. A load matches its context's mask against all stored tags, so it sees only stores on its own speculative lineage, plus stores that are already non-speculative (tag zero).

Path IDs come from a 16-bit free pool, and the lowest free bit is granted first. When a branch executes, the block gives the continuing context a fresh ID. It can also give a fresh ID to a second context that takes the other direction. Both new masks inherit the mask of the branching context. When a branch resolves, its ID is removed from every tag and mask and goes back to the pool. The stores stamped with it are then either made non-speculative or dropped. A load query returns a per-slot candidate vector that is also qualified by an exact address match, and it reports the youngest candidate.

Store insertion is a valid/ready stream. `st_ready` is high while any buffer slot is free. A store transfers in a cycle where `st_valid` and `st_ready` are both high. When `st_ready` is low, the producer holds its store, and the block records nothing. Branch, resolve, drain and load pins are plain single-cycle controls.

Top module: `spec_store_tracker`

## Requirements
- R1: After reset, no store is buffered (`st_ready`=1, `ld_cand` all zero for any query). Every context holds tag 0 and mask 0, and all 16 IDs are free.
- R2: An accepted branch on context c gives c the lowest free ID k (`br_id_a`=k). The tag of c becomes bit k, and its mask becomes its old mask OR bit k. With `br_fork`=1, context `br_fork_ctx` gets the next-lowest free ID j (`br_id_b`=j), with tag bit j and mask equal to the old mask of c OR bit j. Granted IDs leave the pool.
- R3: `br_stall` is high in a cycle where `br_valid`=1 and fewer than one free ID exists, or fewer than two when `br_fork`=1. In that case no ID is taken and no context changes.
- R4: `st_ready`=1 exactly when a slot is free. An accepted store goes into the lowest-numbered free slot (`st_slot`) with its address and with the tag its context held before any same-cycle branch. While `st_ready`=0, a store is not recorded.
- R5: `ld_cand[i]`=1 when slot i is valid, its address equals `ld_addr`, and its tag is zero or shares a set bit with the mask of `ld_ctx`. The output is combinational on the current state.
- R6: `ld_hit` is the OR of `ld_cand`. `ld_hit_slot` is the most recently inserted candidate.
- R7: A resolve of ID k with `rs_correct`=1 clears the tag of every store stamped exactly bit k to zero. It removes bit k from every context tag and mask and returns k to the pool, where the lowest-first grant can reuse it.
- R8: A resolve of ID k with `rs_correct`=0 removes every store stamped exactly bit k. This includes a store accepted in the same cycle with that tag. Bit k is cleared and freed as in R7.
- R9: `dr_valid` frees slot `dr_slot` at the next edge. A drain takes effect before a same-cycle insert.
- R10: An ID freed by a resolve cannot be granted in the same cycle. A branch accepted in that cycle builds its masks without the resolved bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Branch executed on `br_ctx` |
| br_ctx | input | 3 | Context that executed the branch |
| br_fork | input | 1 | Also start the other direction on `br_fork_ctx` |
| br_fork_ctx | input | 3 | Context taking the other direction (must differ from `br_ctx`) |
| br_stall | output | 1 | Not enough free IDs, branch not taken |
| br_id_a | output | 4 | ID granted to `br_ctx` |
| br_id_b | output | 4 | ID granted to `br_fork_ctx` |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | A buffer slot is free |
| st_ctx | input | 3 | Context issuing the store |
| st_addr | input | 16 | Store address |
| st_slot | output | 4 | Slot the offered store goes to |
| ld_valid | input | 1 | Load query enable |
| ld_ctx | input | 3 | Context issuing the load |
| ld_addr | input | 16 | Load address |
| ld_cand | output | 16 | Per-slot candidates for aliasing |
| ld_hit | output | 1 | At least one candidate |
| ld_hit_slot | output | 4 | Youngest candidate slot |
| rs_valid | input | 1 | Branch resolved |
| rs_id | input | 4 | ID of the resolved path |
| rs_correct | input | 1 | 1: path correct, 0: path wrong |
| dr_valid | input | 1 | Drain a slot |
| dr_slot | input | 4 | Slot to free |

## Verification
The bench checks lineage inheritance across a second fork. A child that dropped its parent's mask would miss the parent's stores, and one that kept the sibling's bit would see stores it must not. It exhausts the ID pool and tries a two-ID fork with one ID left, which exposes an allocator that grants a partial pair or burns IDs while stalled. It overlaps a resolve with a branch and with a store of the resolved tag. A design that recycles a freed ID too early, keeps a stale bit in a new mask, or admits a store from a squashed path is caught when a later path reuses that ID. It also fills the buffer and then drains it around squashed holes, where a wrong age order reports a stale youngest slot.

// File: rtl/sst_pkg.sv
package sst_pkg;

  // index of the lowest set bit (0 when none); vectors up to 64 bits
  function automatic int first_set(input logic [63:0] v);
    int r;
    r = 0;
    for (int i = 63; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/sst_id_alloc.sv
module sst_id_alloc #(
  parameter int NUM_IDS = 16,
  localparam int IW = $clog2(NUM_IDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               two,
  input  logic [NUM_IDS-1:0] rbit,
  output logic               stall,
  output logic               accept,
  output logic [IW-1:0]      id_a,
  output logic [IW-1:0]      id_b,
  output logic [NUM_IDS-1:0] bit_a,
  output logic [NUM_IDS-1:0] bit_b,
  output logic [NUM_IDS-1:0] free_map
);
  import sst_pkg::*;

  logic [NUM_IDS-1:0] free_q;
  logic [NUM_IDS-1:0] rest;
  logic [NUM_IDS-1:0] take;

  // isolate lowest and second-lowest free bits
  assign bit_a = free_q & (~free_q + NUM_IDS'(1));
  assign rest  = free_q & ~bit_a;
  assign bit_b = rest & (~rest + NUM_IDS'(1));
  assign id_a  = IW'(first_set(64'(bit_a)));
  assign id_b  = IW'(first_set(64'(bit_b)));

  assign stall  = req & ((free_q == '0) | (two & (rest == '0)));
  assign accept = req & ~stall;
  assign take   = accept ? (bit_a | (two ? bit_b : '0)) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) free_q <= '1;
    else        free_q <= (free_q & ~take) | rbit;
  end

  assign free_map = free_q;

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && (rbit == '0)) |=> $stable(free_q));

  // R7
  freed_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rbit != '0) |=> ((free_q & $past(rbit)) == $past(rbit)));

endmodule

// File: rtl/sst_ctx_state.sv
module sst_ctx_state #(
  parameter int NUM_CTX = 8,
  parameter int NUM_IDS = 16,
  localparam int CW = $clog2(NUM_CTX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               br_go,
  input  logic [CW-1:0]      br_ctx,
  input  logic               two,
  input  logic [CW-1:0]      fork_ctx,
  input  logic [NUM_IDS-1:0] bit_a,
  input  logic [NUM_IDS-1:0] bit_b,
  input  logic [NUM_IDS-1:0] rbit,
  input  logic [CW-1:0]      st_ctx,
  input  logic [CW-1:0]      ld_ctx,
  output logic [NUM_IDS-1:0] st_tag,
  output logic [NUM_IDS-1:0] ld_mask,
  output logic [NUM_IDS-1:0] mask_union
);

  logic [NUM_IDS-1:0] tag_all  [NUM_CTX];
  logic [NUM_IDS-1:0] mask_all [NUM_CTX];
  logic [NUM_IDS-1:0] parent;

  assign parent = mask_all[br_ctx];

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
    logic [NUM_IDS-1:0] tag_q, mask_q, tag_d, mask_d;

    always_comb begin
      tag_d  = tag_q;
      mask_d = mask_q;
      if (br_go && (br_ctx == CW'(g))) begin
        tag_d  = bit_a;
        mask_d = parent | bit_a;
      end
      if (br_go && two && (fork_ctx == CW'(g))) begin
        tag_d  = bit_b;
        mask_d = parent | bit_b;
      end
      // a resolved ID vanishes from every lineage
      tag_d  = tag_d & ~rbit;
      mask_d = mask_d & ~rbit;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_q  <= '0;
        mask_q <= '0;
      end else begin
        tag_q  <= tag_d;
        mask_q <= mask_d;
      end
    end

    assign tag_all[g]  = tag_q;
    assign mask_all[g] = mask_q;

    // R2
    tag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tag_q));

    // R2
    mask_holds_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((tag_q & ~mask_q) == '0));
  end

  assign st_tag  = tag_all[st_ctx];
  assign ld_mask = mask_all[ld_ctx];

  always_comb begin
    mask_union = '0;
    for (int c = 0; c < NUM_CTX; c++) mask_union = mask_union | mask_all[c];
  end

endmodule

// File: rtl/sst_store_buf.sv
module sst_store_buf #(
  parameter int SB_DEPTH = 16,
  parameter int NUM_IDS  = 16,
  parameter int AW       = 16,
  localparam int SLW = $clog2(SB_DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ins_valid,
  output logic                ins_ready,
  input  logic [NUM_IDS-1:0]  ins_tag,
  input  logic [AW-1:0]       ins_addr,
  output logic [SLW-1:0]      ins_slot,
  input  logic                dr_valid,
  input  logic [SLW-1:0]      dr_slot,
  input  logic [NUM_IDS-1:0]  rbit,
  input  logic                rs_ok,
  input  logic                ld_valid,
  input  logic [NUM_IDS-1:0]  ld_mask,
  input  logic [AW-1:0]       ld_addr,
  output logic [SB_DEPTH-1:0] cand,
  output logic                hit,
  output logic [SLW-1:0]      hit_slot
);
  import sst_pkg::*;

  logic [SB_DEPTH-1:0] valid;
  logic [SB_DEPTH-1:0] sel;
  logic [SB_DEPTH-1:0] win;
  logic                ins_go;

  assign ins_ready = ~&valid;
  assign sel       = ~valid & (valid + SB_DEPTH'(1));
  assign ins_slot  = SLW'(first_set(64'(sel)));
  assign ins_go    = ins_valid & ins_ready;

  for (genvar g = 0; g < SB_DEPTH; g++) begin : g_ent
    localparam logic [SB_DEPTH-1:0] SELF = SB_DEPTH'(1) << g;
    logic                v_q, v_d;
    logic [NUM_IDS-1:0]  t_q, t_d;
    logic [AW-1:0]       a_q, a_d;
    logic [SB_DEPTH-1:0] y_q, y_d;   // y_q[j]: this entry is younger than j

    always_comb begin
      v_d = v_q;
      t_d = t_q;
      a_d = a_q;
      y_d = y_q;
      if (dr_valid && (dr_slot == SLW'(g))) v_d = 1'b0;
      if (ins_go) begin
        if (sel[g]) begin
          v_d = 1'b1;
          t_d = ins_tag;
          a_d = ins_addr;
          y_d = valid & ~SELF;
        end else begin
          y_d = y_q & ~sel;
        end
      end
      if ((rbit != '0) && (t_d == rbit)) begin
        if (rs_ok) t_d = '0;
        else       v_d = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
        a_q <= '0;
        y_q <= '0;
      end else begin
        v_q <= v_d;
        t_q <= t_d;
        a_q <= a_d;
        y_q <= y_d;
      end
    end

    assign valid[g] = v_q;
    assign cand[g]  = ld_valid & v_q & (a_q == ld_addr) &
                      ((t_q == '0) | ((t_q & ld_mask) != '0));
    assign win[g]   = cand[g] & (&(~cand | y_q | SELF));
  end

  assign hit      = |win;
  assign hit_slot = SLW'(first_set(64'(win)));

  // R6
  one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win));

  // R6
  hit_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> cand[hit_slot]);

  // R4
  ins_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_go && (ins_tag == '0)) |=> valid[$past(ins_slot)]);

  // R9
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && !(ins_go && sel[dr_slot])) |=> !valid[$past(dr_slot)]);

endmodule

// File: rtl/spec_store_tracker.sv
module spec_store_tracker #(
  parameter int NUM_IDS  = 16,
  parameter int SB_DEPTH = 16,
  parameter int NUM_CTX  = 8,
  parameter int AW       = 16,
  localparam int IW  = $clog2(NUM_IDS),
  localparam int SLW = $clog2(SB_DEPTH),
  localparam int CW  = $clog2(NUM_CTX)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                br_valid,
  input  logic [CW-1:0]       br_ctx,
  input  logic                br_fork,
  input  logic [CW-1:0]       br_fork_ctx,
  output logic                br_stall,
  output logic [IW-1:0]       br_id_a,
  output logic [IW-1:0]       br_id_b,
  input  logic                st_valid,
  output logic                st_ready,
  input  logic [CW-1:0]       st_ctx,
  input  logic [AW-1:0]       st_addr,
  output logic [SLW-1:0]      st_slot,
  input  logic                ld_valid,
  input  logic [CW-1:0]       ld_ctx,
  input  logic [AW-1:0]       ld_addr,
  output logic [SB_DEPTH-1:0] ld_cand,
  output logic                ld_hit,
  output logic [SLW-1:0]      ld_hit_slot,
  input  logic                rs_valid,
  input  logic [IW-1:0]       rs_id,
  input  logic                rs_correct,
  input  logic                dr_valid,
  input  logic [SLW-1:0]      dr_slot
);

  logic [NUM_IDS-1:0] rbit, bit_a, bit_b, free_map;
  logic [NUM_IDS-1:0] st_tag, ld_mask, mask_union;
  logic               br_go;

  assign rbit = rs_valid ? (NUM_IDS'(1) << rs_id) : '0;

  sst_id_alloc #(.NUM_IDS(NUM_IDS)) u_alloc (
    .clk(clk), .rst_n(rst_n),
    .req(br_valid), .two(br_fork), .rbit(rbit),
    .stall(br_stall), .accept(br_go),
    .id_a(br_id_a), .id_b(br_id_b),
    .bit_a(bit_a), .bit_b(bit_b), .free_map(free_map)
  );

  sst_ctx_state #(.NUM_CTX(NUM_CTX), .NUM_IDS(NUM_IDS)) u_ctx (
    .clk(clk), .rst_n(rst_n),
    .br_go(br_go), .br_ctx(br_ctx), .two(br_fork), .fork_ctx(br_fork_ctx),
    .bit_a(bit_a), .bit_b(bit_b), .rbit(rbit),
    .st_ctx(st_ctx), .ld_ctx(ld_ctx),
    .st_tag(st_tag), .ld_mask(ld_mask), .mask_union(mask_union)
  );

  sst_store_buf #(.SB_DEPTH(SB_DEPTH), .NUM_IDS(NUM_IDS), .AW(AW)) u_sb (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(st_valid), .ins_ready(st_ready),
    .ins_tag(st_tag), .ins_addr(st_addr), .ins_slot(st_slot),
    .dr_valid(dr_valid), .dr_slot(dr_slot),
    .rbit(rbit), .rs_ok(rs_correct),
    .ld_valid(ld_valid), .ld_mask(ld_mask), .ld_addr(ld_addr),
    .cand(ld_cand), .hit(ld_hit), .hit_slot(ld_hit_slot)
  );

  // R7
  free_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_union & free_map) == '0));

endmodule

// File: tb/sim_spec_store_tracker.sv
`timescale 1ns/1ps
module sim_spec_store_tracker;
  localparam int NI = 16;
  localparam int NS = 16;
  localparam int NC = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        br_valid, br_fork, br_stall;
  logic [2:0]  br_ctx, br_fork_ctx;
  logic [3:0]  br_id_a, br_id_b;
  logic        st_valid, st_ready;
  logic [2:0]  st_ctx;
  logic [15:0] st_addr;
  logic [3:0]  st_slot;
  logic        ld_valid, ld_hit;
  logic [2:0]  ld_ctx;
  logic [15:0] ld_addr;
  logic [15:0] ld_cand;
  logic [3:0]  ld_hit_slot;
  logic        rs_valid, rs_correct;
  logic [3:0]  rs_id;
  logic        dr_valid;
  logic [3:0]  dr_slot;

  spec_store_tracker u0 (
    .clk(clk), .rst_n(rst_n),
    .br_valid(br_valid), .br_ctx(br_ctx), .br_fork(br_fork), .br_fork_ctx(br_fork_ctx),
    .br_stall(br_stall), .br_id_a(br_id_a), .br_id_b(br_id_b),
    .st_valid(st_valid), .st_ready(st_ready), .st_ctx(st_ctx), .st_addr(st_addr),
    .st_slot(st_slot),
    .ld_valid(ld_valid), .ld_ctx(ld_ctx), .ld_addr(ld_addr),
    .ld_cand(ld_cand), .ld_hit(ld_hit), .ld_hit_slot(ld_hit_slot),
    .rs_valid(rs_valid), .rs_id(rs_id), .rs_correct(rs_correct),
    .dr_valid(dr_valid), .dr_slot(dr_slot)
  );

  int total = 0;
  int bad   = 0;

  // reference state
  logic [15:0] mtag [NC];
  logic [15:0] mmask[NC];
  logic [15:0] mfree;
  logic        mv   [NS];
  logic [15:0] mst  [NS];
  logic [15:0] maddr[NS];
  int          mseq [NS];
  int          seqc;
  logic [15:0] addrs [3];

  function automatic int lowbit(input logic [15:0] v);
    int r;
    r = -1;
    for (int i = 15; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    br_valid = 0; br_fork = 0; br_ctx = 0; br_fork_ctx = 0;
    st_valid = 0; st_ctx = 0; st_addr = 0;
    rs_valid = 0; rs_id = 0; rs_correct = 0;
    dr_valid = 0; dr_slot = 0;
  endtask

  task automatic op(input bit b, input int bc, input bit bf, input int bfc,
                    input bit s, input int sc, input int sa,
                    input bit r, input int rid, input bit rok,
                    input bit d, input int ds, input string req);
    logic [15:0] rb, ba, bb, ot, stamp;
    int ia, ib, es;
    bit estall, eready;
    @(posedge clk); #1;
    br_valid = b; br_ctx = bc[2:0]; br_fork = bf; br_fork_ctx = bfc[2:0];
    st_valid = s; st_ctx = sc[2:0]; st_addr = sa[15:0];
    rs_valid = r; rs_id = rid[3:0]; rs_correct = rok;
    dr_valid = d; dr_slot = ds[3:0];
    #0.5;
    ia = lowbit(mfree);
    ba = (ia >= 0) ? (16'd1 << ia) : 16'd0;
    ib = lowbit(mfree & ~ba);
    bb = (ib >= 0) ? (16'd1 << ib) : 16'd0;
    estall = b && ((ia < 0) || (bf && (ib < 0)));
    if (b) begin
      chk(br_stall === estall, req, "br_stall", int'(br_stall), int'(estall));
      if (!estall) begin
        chk(br_id_a === ia[3:0], req, "br_id_a", int'(br_id_a), ia);
        if (bf) chk(br_id_b === ib[3:0], req, "br_id_b", int'(br_id_b), ib);
      end
    end
    es = -1;
    for (int i = NS - 1; i >= 0; i--) if (!mv[i]) es = i;
    eready = (es >= 0);
    if (s) begin
      chk(st_ready === eready, req, "st_ready", int'(st_ready), int'(eready));
      if (eready) chk(st_slot === es[3:0], req, "st_slot", int'(st_slot), es);
    end
    // reference update from the pre-edge state
    rb    = r ? (16'd1 << rid) : 16'd0;
    stamp = mtag[sc];
    if (b && !estall) begin
      ot = mmask[bc];
      mtag[bc] = ba; mmask[bc] = ot | ba;
      if (bf) begin mtag[bfc] = bb; mmask[bfc] = ot | bb; end
      mfree = mfree & ~(ba | (bf ? bb : 16'd0));
    end
    if (d) mv[ds] = 1'b0;
    if (s && eready) begin
      mv[es] = 1'b1; mst[es] = stamp; maddr[es] = sa[15:0];
      mseq[es] = seqc; seqc++;
    end
    if (r) begin
      for (int c = 0; c < NC; c++) begin
        mtag[c]  = mtag[c] & ~rb;
        mmask[c] = mmask[c] & ~rb;
      end
      mfree = mfree | rb;
      for (int i = 0; i < NS; i++) begin
        if (mv[i] && (mst[i] == rb)) begin
          if (rok) mst[i] = 16'd0;
          else     mv[i]  = 1'b0;
        end
      end
    end
    @(posedge clk); #1;
    idle_inputs();
  endtask

  task automatic br(input int c, input bit f, input int fc, input string q);
    op(1, c, f, fc, 0, 0, 0, 0, 0, 0, 0, 0, q);
  endtask
  task automatic st(input int c, input int a, input string q);
    op(0, 0, 0, 0, 1, c, a, 0, 0, 0, 0, 0, q);
  endtask
  task automatic rs(input int id, input bit ok, input string q);
    op(0, 0, 0, 0, 0, 0, 0, 1, id, ok, 0, 0, q);
  endtask
  task automatic dr(input int s, input string q);
    op(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, s, q);
  endtask

  // every context against every test address
  task automatic sweep(input string req);
    logic [15:0] ec;
    int eslot, best;
    for (int c = 0; c < NC; c++) begin
      for (int ai = 0; ai < 3; ai++) begin
        @(negedge clk);
        ld_valid = 1; ld_ctx = c[2:0]; ld_addr = addrs[ai];
        #1;
        ec = 16'd0; eslot = -1; best = -1;
        for (int i = 0; i < NS; i++) begin
          if (mv[i] && (maddr[i] == addrs[ai]) &&
              ((mst[i] == 16'd0) || ((mst[i] & mmask[c]) != 16'd0))) begin
            ec[i] = 1'b1;
            if (mseq[i] > best) begin best = mseq[i]; eslot = i; end
          end
        end
        chk(ld_cand === ec, {req, "/R5"}, "ld_cand", int'(ld_cand), int'(ec));
        chk(ld_hit === (ec != 16'd0), {req, "/R6"}, "ld_hit", int'(ld_hit), int'(ec != 16'd0));
        if (eslot >= 0)
          chk(ld_hit_slot === eslot[3:0], {req, "/R6"}, "ld_hit_slot", int'(ld_hit_slot), eslot);
      end
    end
    @(negedge clk);
    ld_valid = 0;
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    addrs[0] = 16'h0010; addrs[1] = 16'h0020; addrs[2] = 16'h0030;
    for (int c = 0; c < NC; c++) begin mtag[c] = 0; mmask[c] = 0; end
    for (int i = 0; i < NS; i++) begin mv[i] = 0; mst[i] = 0; maddr[i] = 0; mseq[i] = 0; end
    mfree = 16'hFFFF; seqc = 0;
    rst_n = 0; ld_valid = 0; ld_ctx = 0; ld_addr = 0;
    idle_inputs();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #0.5;
    // R1 empty buffer after reset
    chk(st_ready === 1'b1, "R1", "st_ready", int'(st_ready), 1);
    sweep("R1");

    // non-speculative stores seen by every context
    st(0, 16'h0010, "R4");
    st(0, 16'h0020, "R4");
    sweep("R5");

    // fork: ctx0 gets ID0, ctx1 gets ID1
    br(0, 1, 1, "R2");
    st(0, 16'h0010, "R4");
    st(1, 16'h0010, "R4");
    sweep("R6");

    // second fork inherits parent lineage: IDs 2 and 3
    br(1, 1, 2, "R2");
    st(2, 16'h0010, "R4");
    st(1, 16'h0030, "R4");
    sweep("R2");

    dr(0, "R9");
    sweep("R9");

    // correct resolve commits stores, ID 0 reused lowest-first
    rs(0, 1, "R7");
    sweep("R7");
    br(3, 0, 0, "R7");

    // wrong resolve squashes stores tagged ID1
    rs(1, 0, "R8");
    sweep("R8");

    // exhaust the pool: 13 free IDs, two-ID fork refused with one left
    for (int k = 0; k < 12; k++) br(4, 0, 0, "R2");
    br(5, 1, 6, "R3");
    br(4, 0, 0, "R2");
    br(4, 0, 0, "R3");
    sweep("R3");

    st(4, 16'h0020, "R4");
    // resolve and branch together: freed ID not yet grantable
    op(1, 5, 0, 0, 0, 0, 0, 1, 15, 0, 0, 0, "R10");
    br(5, 0, 0, "R10");
    rs(5, 1, "R7");
    // branch gets ID5 while ID6 resolves: new mask lacks bit 6
    op(1, 4, 0, 0, 0, 0, 0, 1, 6, 1, 0, 0, "R10");
    br(7, 0, 0, "R10");
    st(7, 16'h0030, "R10");
    sweep("R10");

    // fill the buffer and push against back-pressure
    for (int k = 0; k < 13; k++) st(6, int'(addrs[k % 3]), "R4");
    sweep("R4");

    // same-cycle store of a squashed tag is dropped
    dr(3, "R9");
    op(0, 0, 0, 0, 1, 7, 16'h0030, 1, 6, 0, 0, 0, "R8");
    sweep("R8");
    st(0, 16'h0010, "R4");

    for (int s = 0; s < NS; s++) dr(s, "R9");
    sweep("R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule